// File: doc/BRIEF.md
# Self-ID Stream Sequencer

After a bus reset, every node on the serial bus announces itself with a self-ID quadlet, and the link receives these announcements as a word stream. The stream also carries framing words. This block cleans that stream up. It discards the framing words and checks each announcement against the inverted copy that follows it. It then passes on only the first word of every intact pair. The result is an ordered list of quadlets that a bus-management agent can consume directly.

A node does not receive its own announcement, so the block merges in a locally built quadlet supplied on `own_selfid`, keeping the list in ascending node-number order:

- When a node whose number is one above the local one arrives, the local quadlet is placed in front of it.
- When the received byte count shows that only the two framing words were captured (a lone node), the local quadlet is emitted by itself at the start.
- When the local node is root with a nonzero number, its quadlet goes last.

When the list is finished, a one-cycle completion pulse reports the local node number and the root flag.

The configuration inputs (`own_phy_id`, `own_is_root`, `own_selfid`, `rx_byte_cnt`) are sampled in the first cycle in which `in_valid` is seen while the block is idle. They must stay stable for the rest of that stream.

Top module: `sid_stream_seq`

## Requirements
- R1: The input word 0x000000E0 is a framing word. It is discarded, never appears as a forwarded packet, and takes 4 bytes from the byte budget.
- R2: The input word 0x00000001 closes the stream at once, even without `in_last`. The completion pulse follows without any further input word being taken.
- R3: Two consecutive words where the second equals the bitwise inverse of the first form an intact packet. Only the first word is forwarded, in arrival order, and the pair takes 8 bytes.
- R4: The local quadlet is emitted directly before an intact packet whose bits 29:24 equal the local node number plus one and whose bit 23 is 0. A packet with bit 23 set, or one whose number does not match, gets no insertion.
- R5: When `rx_byte_cnt` equals 8, the local quadlet is emitted exactly once, ahead of anything else in that stream.
- R6: When `own_is_root` is 1 and `own_phy_id` is nonzero, the local quadlet is emitted after every forwarded packet. A root with number 0 gets no appended quadlet.
- R7: `done` is high for exactly one cycle, only after the last quadlet of the stream has been accepted. At that time `done_phy_id` and `done_root` carry the sampled local number and root flag.
- R8: A word that is neither a framing word nor the first half of an intact pair is dropped and sets `fmt_err`; the word after it is evaluated afresh. A half pair left over when the stream closes also sets `fmt_err`. `fmt_err` stays set until the next stream starts.
- R9: The stream closes as soon as the bytes taken reach `rx_byte_cnt`. No further word is accepted after that point.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data` is held unchanged, and no quadlet is lost or repeated under any pattern of `out_ready`.
- R11: After reset, `out_valid`, `done`, `fmt_err` and `in_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Input word taken at this edge when `in_valid` is also 1 |
| in_data | input | 32 | Received word |
| in_last | input | 1 | Marks the final word of the stream |
| own_phy_id | input | 6 | Local node number |
| own_is_root | input | 1 | Local node is root |
| own_selfid | input | 32 | Locally built self-ID quadlet |
| rx_byte_cnt | input | CNT_W | Bytes captured for this stream |
| out_valid | output | 1 | Output quadlet present |
| out_ready | input | 1 | Sink accepts the output quadlet |
| out_data | output | 32 | Ordered self-ID quadlet |
| done | output | 1 | One-cycle completion pulse |
| done_phy_id | output | 6 | Local node number, valid with `done` |
| done_root | output | 1 | Root flag, valid with `done` |
| fmt_err | output | 1 | Sticky malformed-word flag for the current stream |

## Verification
An intact pair's forwarded word, or the local quadlet placed in front of it, becomes visible one cycle after the pair's second word is taken. A packet that waits behind an inserted quadlet appears once that quadlet has been accepted. The completion pulse rises in the cycle after the final quadlet is accepted. Because the sink's ready may stall at any time, the monitor never counts fixed cycle offsets. Instead it samples at the falling edge, compares only on cycles where `out_valid` and `out_ready` are both high, and therefore sees each quadlet exactly once, in order. At the completion pulse it requires the expected queue to be empty, which confirms the pulse came after the last accept.

// File: rtl/sid_pkg.sv
package sid_pkg;
    localparam int QW        = 32;
    localparam int PHY_ID_W  = 6;
    localparam int ID_LSB    = 24;
    localparam int USED_W    = 4;
    localparam logic [QW-1:0] BEGIN_MARK = 32'h0000_00E0;
    localparam logic [QW-1:0] END_MARK   = 32'h0000_0001;
    localparam logic [USED_W-1:0] WORD_BYTES = 4'd4;
    localparam logic [USED_W-1:0] PAIR_BYTES = 4'd8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_RUN,
        ST_FLUSH,
        ST_TAIL,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        logic              fwd;
        logic              own_first;
        logic              hold_set;
        logic              hold_clr;
        logic              drop;
        logic              stop;
        logic [USED_W-1:0] used;
        logic [QW-1:0]     fwd_q;
        logic [QW-1:0]     hold_q;
    } word_act_t;

    function automatic logic follows_own(input logic [QW-1:0] q,
                                         input logic [PHY_ID_W-1:0] own);
        logic [PHY_ID_W:0] nxt;
        nxt = {1'b0, own} + 1'b1;
        return !nxt[PHY_ID_W]
            && (q[ID_LSB +: PHY_ID_W] == nxt[PHY_ID_W-1:0])
            && !q[ID_LSB-1];
    endfunction
endpackage

// File: rtl/sid_word_classifier.sv
module sid_word_classifier
    import sid_pkg::*;
(
    input  logic                held_v,
    input  logic [QW-1:0]       held_q,
    input  logic [QW-1:0]       word,
    input  logic [PHY_ID_W-1:0] own_id,
    output word_act_t           act
);
    always_comb begin
        act = '0;
        if (held_v && (word == ~held_q)) begin
            act.fwd       = 1'b1;
            act.fwd_q     = held_q;
            act.own_first = follows_own(held_q, own_id);
            act.hold_clr  = 1'b1;
            act.used      = PAIR_BYTES;
        end else begin
            if (held_v) begin
                act.drop     = 1'b1;
                act.hold_clr = 1'b1;
                act.used     = WORD_BYTES;
            end
            if (word == BEGIN_MARK) begin
                act.used = act.used + WORD_BYTES;
            end else if (word == END_MARK) begin
                act.stop = 1'b1;
            end else begin
                act.hold_set = 1'b1;
                act.hold_q   = word;
            end
        end
    end

    always_comb begin
        assert (!(act.fwd && act.drop)); // R3: a pair is never also a dropped word
    end
endmodule

// File: rtl/sid_byte_budget.sv
module sid_byte_budget
    import sid_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [CNT_W-1:0]  load_val,
    input  logic              dec,
    input  logic [USED_W-1:0] dec_amt,
    output logic [CNT_W-1:0]  rem,
    output logic              spent
);
    localparam int PAD_W = CNT_W - USED_W;

    logic [CNT_W-1:0] amt_ext;
    assign amt_ext = {{PAD_W{1'b0}}, dec_amt};
    assign spent   = (amt_ext >= rem);

    always_ff @(posedge clk) begin
        if (rst) begin
            rem <= '0;
        end else if (load) begin
            rem <= load_val;
        end else if (dec && !spent) begin
            rem <= rem - amt_ext;
        end
    end

    p_budget_monotone_r9: assert property (@(posedge clk) disable iff (rst)
        (!load && !$past(load) && !$past(rst)) |-> (rem <= $past(rem)));
endmodule

// File: rtl/sid_out_reg.sv
module sid_out_reg
    import sid_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [QW-1:0] push_q,
    input  logic          out_ready,
    output logic          out_valid,
    output logic [QW-1:0] out_data,
    output logic          can_load
);
    assign can_load = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (can_load) begin
            out_valid <= push;
            if (push) out_data <= push_q;
        end
    end

    p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    p_push_room_r10: assert property (@(posedge clk) disable iff (rst)
        push |-> can_load);
endmodule

// File: rtl/sid_stream_seq.sv
module sid_stream_seq
    import sid_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [QW-1:0]       in_data,
    input  logic                in_last,
    input  logic [PHY_ID_W-1:0] own_phy_id,
    input  logic                own_is_root,
    input  logic [QW-1:0]       own_selfid,
    input  logic [CNT_W-1:0]    rx_byte_cnt,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [QW-1:0]       out_data,
    output logic                done,
    output logic [PHY_ID_W-1:0] done_phy_id,
    output logic                done_root,
    output logic                fmt_err
);
    localparam logic [CNT_W-1:0] LONE_BYTES = CNT_W'(2 * 4);

    seq_state_e          state;
    logic [PHY_ID_W-1:0] cfg_id;
    logic                cfg_root;
    logic [QW-1:0]       cfg_own;
    logic                held_v;
    logic [QW-1:0]       held_q;
    logic                pend_v;
    logic [QW-1:0]       pend_q;
    logic                can_load;
    logic                push;
    logic [QW-1:0]       push_q;
    logic                in_fire;
    logic                spent;
    logic [CNT_W-1:0]    rem;
    logic                end_now;
    logic                tail_need;
    logic                start;
    word_act_t           act;

    sid_word_classifier u_cls (
        .held_v (held_v),
        .held_q (held_q),
        .word   (in_data),
        .own_id (cfg_id),
        .act    (act)
    );

    sid_byte_budget #(.CNT_W(CNT_W)) u_budget (
        .clk      (clk),
        .rst      (rst),
        .load     (start),
        .load_val (rx_byte_cnt),
        .dec      (in_fire),
        .dec_amt  (act.used),
        .rem      (rem),
        .spent    (spent)
    );

    sid_out_reg u_out (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_q    (push_q),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .can_load  (can_load)
    );

    assign start     = (state == ST_IDLE) && in_valid;
    assign in_ready  = (state == ST_RUN) && !pend_v && can_load;
    assign in_fire   = in_valid && in_ready;
    assign end_now   = act.stop || in_last || spent;
    assign tail_need = cfg_root && (cfg_id != '0);

    always_comb begin
        push   = 1'b0;
        push_q = cfg_own;
        unique case (state)
            ST_LEAD: push = can_load;
            ST_RUN, ST_FLUSH: begin
                if (pend_v) begin
                    push   = can_load;
                    push_q = pend_q;
                end else if (in_fire && act.fwd) begin
                    push   = 1'b1;
                    push_q = act.own_first ? cfg_own : act.fwd_q;
                end
            end
            ST_TAIL: push = can_load && tail_need;
            default: push = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_IDLE;
            cfg_id      <= '0;
            cfg_root    <= 1'b0;
            cfg_own     <= '0;
            held_v      <= 1'b0;
            held_q      <= '0;
            pend_v      <= 1'b0;
            pend_q      <= '0;
            fmt_err     <= 1'b0;
            done        <= 1'b0;
            done_phy_id <= '0;
            done_root   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (pend_v && can_load) pend_v <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (in_valid) begin
                        cfg_id   <= own_phy_id;
                        cfg_root <= own_is_root;
                        cfg_own  <= own_selfid;
                        held_v   <= 1'b0;
                        fmt_err  <= 1'b0;
                        state    <= (rx_byte_cnt == LONE_BYTES) ? ST_LEAD : ST_RUN;
                    end
                end
                ST_LEAD: begin
                    if (can_load) state <= ST_RUN;
                end
                ST_RUN: begin
                    if (in_fire) begin
                        if (act.hold_clr) held_v <= 1'b0;
                        if (act.hold_set) begin
                            held_v <= 1'b1;
                            held_q <= act.hold_q;
                        end
                        if (act.fwd && act.own_first) begin
                            pend_v <= 1'b1;
                            pend_q <= act.fwd_q;
                        end
                        if (act.drop) fmt_err <= 1'b1;
                        if (end_now) begin
                            held_v <= 1'b0;
                            if (act.hold_set) fmt_err <= 1'b1;
                            state <= ST_FLUSH;
                        end
                    end
                end
                ST_FLUSH: begin
                    if (!pend_v) state <= ST_TAIL;
                end
                ST_TAIL: begin
                    if (!tail_need || can_load) state <= ST_FIN;
                end
                ST_FIN: begin
                    if (!out_valid || out_ready) begin
                        done        <= 1'b1;
                        done_phy_id <= cfg_id;
                        done_root   <= cfg_root;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_reset_quiet_r11: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !done && !fmt_err && !in_ready));
    p_own_ahead_r4: assert property (@(posedge clk) disable iff (rst)
        (in_fire && act.fwd && act.own_first) |=> (out_valid && out_data == cfg_own));
    p_mark_hidden_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_data == BEGIN_MARK) |-> (out_data == cfg_own));
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_drained_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> !out_valid);
    p_budget_close_r9: assert property (@(posedge clk) disable iff (rst)
        (in_fire && spent) |=> !in_ready);
    p_stop_close_r2: assert property (@(posedge clk) disable iff (rst)
        (in_fire && act.stop) |=> !in_ready);
    p_drop_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (in_fire && act.drop) |=> fmt_err);
endmodule

// File: tb/sid_stream_seq_tb_top.sv
module sid_stream_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid, in_ready, in_last;
    logic [31:0] in_data;
    logic [5:0]  own_phy_id;
    logic        own_is_root;
    logic [31:0] own_selfid;
    logic [15:0] rx_byte_cnt;
    logic        out_valid, out_ready;
    logic [31:0] out_data;
    logic        done, done_root, fmt_err;
    logic [5:0]  done_phy_id;

    always #5 clk = ~clk;

    sid_stream_seq #(.CNT_W(16)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .in_last(in_last), .own_phy_id(own_phy_id),
        .own_is_root(own_is_root), .own_selfid(own_selfid),
        .rx_byte_cnt(rx_byte_cnt), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .done(done), .done_phy_id(done_phy_id),
        .done_root(done_root), .fmt_err(fmt_err)
    );

    logic [31:0] exp_q[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done_seen = 0;
    logic [5:0]  exp_id;
    logic        exp_root;
    logic        exp_err;
    string       cur_tag = "R3";
    bit          stall_mode = 0;
    logic [7:0]  lfsr = 8'h5a;
    logic        prev_stall = 0;
    logic [31:0] prev_data = '0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] sid(input logic [5:0] id, input logic link);
        return {2'b10, id, link, 7'h3f, 16'h1200 + {10'd0, id}};
    endfunction

    function automatic logic [31:0] own_q(input logic [5:0] id);
        return {2'b10, id, 1'b1, 7'h3f, 16'hbeef};
    endfunction

    always @(posedge clk) begin
        #2;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = stall_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_stall) begin
                check("R10 held data", out_data, prev_data);
                check("R10 held valid", {31'd0, out_valid}, 32'd1);
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    n_cmp++;
                    n_bad++;
                    $display("FAIL %s actual=%h expected=none", cur_tag, out_data);
                end else begin
                    check(cur_tag, out_data, exp_q.pop_front());
                end
            end
            if (done) begin
                check("R7 done id", {26'd0, done_phy_id}, {26'd0, exp_id});
                check("R7 done root", {31'd0, done_root}, {31'd0, exp_root});
                check("R7 all accepted before done", exp_q.size(), 32'd0);
                check("R8 fmt_err at done", {31'd0, fmt_err}, {31'd0, exp_err});
                done_seen = 1;
            end
        end
    end

    task automatic put(input logic [31:0] w, input logic last);
        in_valid = 1'b1;
        in_data  = w;
        in_last  = last;
        forever begin
            @(negedge clk);
            if (in_ready) break;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic run(input string tag, input logic [5:0] id, input logic root,
                       input logic [15:0] bytes, input logic err,
                       input logic [31:0] w[], input int last_idx);
        cur_tag     = tag;
        own_phy_id  = id;
        own_is_root = root;
        own_selfid  = own_q(id);
        rx_byte_cnt = bytes;
        exp_id      = id;
        exp_root    = root;
        exp_err     = err;
        done_seen   = 0;
        foreach (w[i]) put(w[i], i == last_idx);
        while (!done_seen) @(negedge clk);
        repeat (3) @(negedge clk);
        check({tag, " idle after done"}, {31'd0, in_ready}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst = 1'b1; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
        own_phy_id = '0; own_is_root = 1'b0; own_selfid = '0; rx_byte_cnt = '0;
        out_ready = 1'b1;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check("R11 out_valid", {31'd0, out_valid}, 32'd0);
        check("R11 done", {31'd0, done}, 32'd0);
        check("R11 fmt_err", {31'd0, fmt_err}, 32'd0);
        check("R11 in_ready", {31'd0, in_ready}, 32'd0);

        // R1 R3 R4: own id 2 goes ahead of node 3 (link bit 0)
        exp_q = '{sid(0,1), sid(1,1), own_q(2), sid(3,0)};
        run("R4 insert ahead", 6'd2, 1'b0, 16'd32, 1'b0,
            '{32'he0, sid(0,1), ~sid(0,1), sid(1,1), ~sid(1,1), sid(3,0), ~sid(3,0), 32'h1}, 7);

        // R4: link bit set on node 3 prevents insertion
        exp_q = '{sid(0,1), sid(1,1), sid(3,1)};
        run("R4 link bit blocks", 6'd2, 1'b0, 16'd32, 1'b0,
            '{32'he0, sid(0,1), ~sid(0,1), sid(1,1), ~sid(1,1), sid(3,1), ~sid(3,1), 32'h1}, 7);

        // R6: root with nonzero id appended last, under backpressure (R10)
        stall_mode = 1;
        exp_q = '{sid(0,1), sid(1,1), own_q(2)};
        run("R6 root append", 6'd2, 1'b1, 16'd24, 1'b0,
            '{32'he0, sid(0,1), ~sid(0,1), sid(1,1), ~sid(1,1), 32'h1}, 5);

        // R5 R6: lone node, byte count 8, root id 0 gets no append
        exp_q = '{own_q(0)};
        run("R5 lone node", 6'd0, 1'b1, 16'd8, 1'b0, '{32'he0, 32'h1}, 1);

        // R8: malformed word dropped, following words re-evaluated
        exp_q = '{sid(0,1), sid(1,1)};
        run("R8 drop malformed", 6'd5, 1'b0, 16'd28, 1'b1,
            '{32'he0, 32'h1234_5678, sid(0,1), ~sid(0,1), sid(1,1), ~sid(1,1), 32'h1}, 6);

        // R2: end marker closes without in_last; also R8 flag cleared on new stream
        stall_mode = 0;
        exp_q = '{sid(0,1)};
        run("R2 end marker", 6'd4, 1'b0, 16'd200, 1'b0,
            '{32'he0, sid(0,1), ~sid(0,1), 32'h1}, -1);

        // R9: byte budget exhausted after one pair, no in_last
        exp_q = '{sid(0,1)};
        run("R9 budget", 6'd4, 1'b0, 16'd12, 1'b0,
            '{32'he0, sid(0,1), ~sid(0,1)}, -1);

        // R8: half pair left at close raises the flag; R4 own id 0 ahead of node 1
        stall_mode = 1;
        exp_q = '{own_q(0), sid(1,0)};
        run("R8 half pair at close", 6'd0, 1'b0, 16'd100, 1'b1,
            '{32'he0, sid(1,0), ~sid(1,0), sid(2,1)}, 3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule